// File: doc/BRIEF.md
# Serial Program Loader with Automatic Rate Detection

This block lets a host fill a small processor's instruction store over a plain asynchronous serial line and later read back the processor's data store over the same line. No baud rate is configured. After reset the block waits for a calibration byte of value 0x55. That byte's start bit and data bits alternate low and high, so the line toggles once per bit period. The block counts clock cycles across eight of those toggles and keeps the result as its bit period for both directions.

The block then accepts a fixed-length image of 64 bytes. It packs the bytes into sixteen 32-bit instruction words, and the processor reads those words through a combinational port. While the image is loading, the block holds the processor in reset. After the last image byte it releases the processor and enters a readback state, which it keeps until the next reset. In that state every received byte, whatever its value, starts a transmission of the four-word data store, which the processor writes through a simple write port. Four status outputs drive indicator LEDs.

Top module: `uart_loader`

## Requirements
- R1: While reset is asserted and directly after it, `tx` is 1, `led_prog` is 1, `core_rst_n` is 0, `led_tx` is 0 and `led_rx` is 0.
- R2: The bit period is taken from the first byte after reset, which must be 0x55 framed 8N1. Rounded, it equals one eighth of the cycles between that byte's falling start edge and the falling edge that begins its bit 7. Image reception and readback at two different rates (8 and 12 cycles per bit) both decode and encode correctly.
- R3: Image byte n (n = 0..63, counted after the calibration byte) is stored in instruction word n/4 at bits 8*(n%4)+7 : 8*(n%4), so the first byte lands in bits 7:0 of word 0. `imem_rd` shows word `imem_ra` combinationally.
- R4: After 63 image bytes the block is still loading (`led_prog` = 1, `core_rst_n` = 0). After the 64th it is in readback (`led_prog` = 0, `core_rst_n` = 1).
- R5: Readback is held until reset, and bytes received in it leave the instruction store unchanged.
- R6: In readback, a received byte of any value sends 16 bytes: data words 0, 1, 2, 3 in that order, each least significant byte first. Each byte is framed as a start bit of 0, eight data bits LSB first and a stop bit of 1, one bit period each.
- R7: A low pulse on `rx` that has ended before half a bit period has passed is not taken as a start bit. It neither stores a byte nor triggers a transmission.
- R8: A byte received while a readback is in progress is remembered, and exactly one more full readback follows the current one. Several such bytes during one readback produce only one extra readback.
- R9: `led_rx` is 1 while a frame is being received. `led_tx` is 1 while a readback is being sent and 0 afterwards. `led_rst` is 1 exactly while `rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx | input | 1 | Serial receive line, idle high |
| tx | output | 1 | Serial transmit line, idle high |
| imem_ra | input | 4 | Instruction word read address from the processor |
| imem_rd | output | 32 | Instruction word at `imem_ra` |
| dmem_we | input | 1 | Data store write enable from the processor |
| dmem_wa | input | 2 | Data store word write address |
| dmem_wd | input | 32 | Data store write data |
| core_rst_n | output | 1 | Processor reset, low while the image is loading |
| led_rx | output | 1 | Receive activity indicator |
| led_tx | output | 1 | Transmit activity indicator |
| led_prog | output | 1 | High while the image is loading |
| led_rst | output | 1 | High while reset is asserted |

## Verification
The receiver and the readback transmitter run concurrently. A trigger byte can therefore finish in the same cycle that a readback ends, or in the cycle that a remembered request launches the next one. The bench provokes this by sending a second trigger at a sweep of offsets: early in a readback, late in it, near its final stop bit and just after it ends. In one case it sends a third trigger as well. Each case is judged by counting exactly 32 correctly ordered bytes on `tx`, followed by a long quiet period with no further frame.

// File: rtl/uart_loader.sv
module uart_loader #(
  parameter int IMEM_WORDS = 16,
  parameter int DMEM_WORDS = 4,
  parameter int CW         = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx,
  output logic                          tx,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_ra,
  output logic [31:0]                   imem_rd,
  input  logic                          dmem_we,
  input  logic [$clog2(DMEM_WORDS)-1:0] dmem_wa,
  input  logic [31:0]                   dmem_wd,
  output logic                          core_rst_n,
  output logic                          led_rx,
  output logic                          led_tx,
  output logic                          led_prog,
  output logic                          led_rst
);
  localparam int IB  = IMEM_WORDS * 4;
  localparam int IAW = $clog2(IB);
  localparam int DB  = DMEM_WORDS * 4;
  localparam int DAW = $clog2(DB);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [1:0] {AB_WAIT, AB_MEAS, AB_TAIL, AB_DONE} ab_t;
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rs_t;

  // input synchroniser and edge detection
  logic rx_m, rx_s, rx_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_m, rx_s, rx_q} <= 3'b111;
    else begin
      rx_m <= rx;
      rx_s <= rx_m;
      rx_q <= rx_s;
    end
  wire rx_fall = rx_q & ~rx_s;
  wire rx_edge = rx_q ^ rx_s;

  // rate measurement over the calibration byte
  ab_t         ab;
  logic [CW-1:0] ab_cnt, bitp;
  logic [2:0]  ab_edges;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ab       <= AB_WAIT;
      ab_cnt   <= '0;
      ab_edges <= '0;
      bitp     <= '0;
    end else begin
      case (ab)
        AB_WAIT: if (rx_fall) begin
          ab_cnt   <= ONE;
          ab_edges <= '0;
          ab       <= AB_MEAS;
        end
        AB_MEAS: begin
          ab_cnt <= ab_cnt + ONE;
          if (rx_edge) begin
            if (ab_edges == 3'd7) begin
              bitp <= CW'((ab_cnt + CW'(4)) >> 3);
              ab   <= AB_TAIL;
            end else ab_edges <= ab_edges + 3'd1;
          end
        end
        AB_TAIL: if (rx_s) ab <= AB_DONE;
        default: ;
      endcase
    end
  wire ab_done = (ab == AB_DONE);
  wire [CW-1:0] half = bitp >> 1;

  // receiver
  rs_t         rs;
  logic [CW-1:0] rcnt;
  logic [2:0]  rbit;
  logic [7:0]  rsh;
  logic        rx_vld;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs     <= R_IDLE;
      rcnt   <= '0;
      rbit   <= '0;
      rsh    <= '0;
      rx_vld <= 1'b0;
    end else begin
      rx_vld <= 1'b0;
      case (rs)
        R_IDLE: if (ab_done && !rx_s) begin
          rcnt <= '0;
          rs   <= R_START;
        end
        R_START: begin
          rcnt <= rcnt + ONE;
          if (rcnt == half - ONE) begin
            rcnt <= '0;
            rbit <= '0;
            rs   <= rx_s ? R_IDLE : R_DATA;
          end
        end
        R_DATA: begin
          rcnt <= rcnt + ONE;
          if (rcnt == bitp - ONE) begin
            rcnt <= '0;
            rsh  <= {rx_s, rsh[7:1]};
            rbit <= rbit + 3'd1;
            if (rbit == 3'd7) rs <= R_STOP;
          end
        end
        default: begin
          rcnt <= rcnt + ONE;
          if (rcnt == bitp - ONE) begin
            rcnt   <= '0;
            rx_vld <= 1'b1;
            rs     <= R_IDLE;
          end
        end
      endcase
    end

  // image loader
  logic           prog;
  logic [IAW-1:0] waddr;
  logic [31:0]    imem [IMEM_WORDS];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prog  <= 1'b1;
      waddr <= '0;
    end else if (rx_vld && prog) begin
      waddr <= waddr + IAW'(1);
      if (waddr == IAW'(IB - 1)) prog <= 1'b0;
    end
  always_ff @(posedge clk)
    if (rx_vld && prog) imem[waddr[IAW-1:2]][8*waddr[1:0] +: 8] <= rsh;
  assign imem_rd = imem[imem_ra];

  // data store
  logic [31:0] dmem [DMEM_WORDS];
  always_ff @(posedge clk)
    if (dmem_we) dmem[dmem_wa] <= dmem_wd;

  // readback transmitter
  logic           busy, pend;
  logic [DAW-1:0] tidx;
  logic [CW-1:0]  tcnt;
  logic [3:0]     tbit;
  logic [9:0]     tsh;
  wire trig = rx_vld & ~prog;
  wire go   = ~busy & (trig | pend);
  wire [DAW-1:0] ld_idx  = go ? '0 : tidx + DAW'(1);
  wire [7:0]     ld_byte = dmem[ld_idx[DAW-1:2]][8*ld_idx[1:0] +: 8];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      tidx <= '0;
      tcnt <= '0;
      tbit <= '0;
      tsh  <= '1;
    end else begin
      if (trig && busy) pend <= 1'b1;
      else if (go)      pend <= 1'b0;
      if (go) begin
        busy <= 1'b1;
        tidx <= '0;
        tcnt <= '0;
        tbit <= '0;
        tsh  <= {1'b1, ld_byte, 1'b0};
      end else if (busy) begin
        if (tcnt == bitp - ONE) begin
          tcnt <= '0;
          if (tbit == 4'd9) begin
            tbit <= '0;
            if (tidx == DAW'(DB - 1)) begin
              busy <= 1'b0;
              tsh  <= '1;
            end else begin
              tidx <= ld_idx;
              tsh  <= {1'b1, ld_byte, 1'b0};
            end
          end else begin
            tbit <= tbit + 4'd1;
            tsh  <= {1'b1, tsh[9:1]};
          end
        end else tcnt <= tcnt + ONE;
      end
    end

  assign tx         = tsh[0];
  assign core_rst_n = ~prog;
  assign led_prog   = prog;
  assign led_tx     = busy;
  assign led_rx     = (rs != R_IDLE);
  assign led_rst    = ~rst_n;

  assert_prog_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |=> !prog);
  assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |=> $stable(waddr));
  assert_line_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  assert_no_dump_loading_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog |-> !busy);
  assert_start_confirmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == R_DATA && $past(rs) == R_START) |-> !$past(rx_s));
  assert_pending_served_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !busy) |=> busy);
  assert_rx_after_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rs != R_IDLE) |-> ab_done);
endmodule

// File: tb/sim_uart_loader.sv
`timescale 1ns/1ps
module sim_uart_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tx;
  logic [3:0] imem_ra = '0;
  logic [31:0] imem_rd;
  logic dmem_we = 1'b0;
  logic [1:0] dmem_wa = '0;
  logic [31:0] dmem_wd = '0;
  logic core_rst_n, led_rx, led_tx, led_prog, led_rst;

  always #4 clk = ~clk;

  uart_loader u0 (.clk(clk), .rst_n(rst_n), .rx(rx), .tx(tx),
    .imem_ra(imem_ra), .imem_rd(imem_rd), .dmem_we(dmem_we),
    .dmem_wa(dmem_wa), .dmem_wd(dmem_wd), .core_rst_n(core_rst_n),
    .led_rx(led_rx), .led_tx(led_tx), .led_prog(led_prog), .led_rst(led_rst));

  int nchk = 0, nfail = 0;
  int P = 8;
  int rcount = 0;
  int stopbad = 0;
  logic [7:0] rxb [256];
  logic [7:0] mon_b;
  logic [7:0] img [64];
  logic [31:0] dw [4];
  logic done = 1'b0;

  // stimulus table: {trigger byte, word3, word2, word1, word0}
  localparam logic [135:0] VEC [4] = '{
    {8'h00, 32'h33221100, 32'h77665544, 32'hBBAA9988, 32'hFFEEDDCC},
    {8'hFF, 32'hDEADBEEF, 32'h00000000, 32'hFFFFFFFF, 32'h12345678},
    {8'h55, 32'h80000001, 32'h01020304, 32'hA5A5A5A5, 32'h5A5A5A5A},
    {8'hA3, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h13579BDF, 32'h2468ACE0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit look_led);
    @(negedge clk) rx = 1'b0;
    repeat (P) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (P) @(negedge clk);
      if (look_led && i == 3) chk("R9 led_rx mid-frame", 64'(led_rx), 64'd1);
    end
    rx = 1'b1;
    repeat (P) @(negedge clk);
  endtask

  task automatic write_dmem(input logic [31:0] w0, w1, w2, w3);
    dw[0] = w0; dw[1] = w1; dw[2] = w2; dw[3] = w3;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dmem_we = 1'b1; dmem_wa = 2'(i); dmem_wd = dw[i];
    end
    @(negedge clk) dmem_we = 1'b0;
  endtask

  task automatic wait_bytes(input int n);
    int t = 0;
    while (rcount < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic chk_dump(input string req, input int base);
    for (int k = 0; k < 16; k++)
      chk(req, 64'(rxb[(base + k) % 256]), 64'(dw[k / 4][8 * (k % 4) +: 8]));
  endtask

  task automatic chk_word(input string req, input int w);
    imem_ra = 4'(w);
    #1;
    chk(req, 64'(imem_rd), 64'({img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]}));
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // serial monitor on tx
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx === 1'b0) begin
        repeat (P / 2) @(negedge clk);
        mon_b = '0;
        for (int i = 0; i < 8; i++) begin
          repeat (P) @(negedge clk);
          mon_b[i] = tx;
        end
        repeat (P) @(negedge clk);
        if (tx !== 1'b1) stopbad++;
        rxb[rcount % 256] = mon_b;
        rcount++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 tx idle", 64'(tx), 64'd1);
    chk("R1 led_prog", 64'(led_prog), 64'd1);
    chk("R1 core_rst_n", 64'(core_rst_n), 64'd0);
    chk("R1 led_tx", 64'(led_tx), 64'd0);
    chk("R1 led_rx", 64'(led_rx), 64'd0);
    chk("R9 led_rst in reset", 64'(led_rst), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 led_rst released", 64'(led_rst), 64'd0);
    chk("R1 led_prog after reset", 64'(led_prog), 64'd1);

    // load an image at 8 cycles per bit, with a glitch after calibration
    P = 8;
    send_byte(8'h55, 1'b0);
    repeat (3 * P) @(negedge clk);
    rx = 1'b0;
    repeat (2) @(negedge clk);
    rx = 1'b1;
    repeat (3 * P) @(negedge clk);
    for (int i = 0; i < 64; i++) img[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 63; i++) send_byte(img[i], i == 10);
    repeat (4) @(negedge clk);
    chk("R4 still loading after 63", 64'(led_prog), 64'd1);
    chk("R4 core held after 63", 64'(core_rst_n), 64'd0);
    send_byte(img[63], 1'b0);
    repeat (4) @(negedge clk);
    chk("R4 readback after 64", 64'(led_prog), 64'd0);
    chk("R4 core released", 64'(core_rst_n), 64'd1);
    chk_word("R7 word0 after glitch", 0);
    for (int w = 0; w < 16; w++) chk_word("R3 packing", w);

    // R6 table of readbacks
    for (int v = 0; v < 4; v++) begin
      write_dmem(VEC[v][31:0], VEC[v][63:32], VEC[v][95:64], VEC[v][127:96]);
      base = rcount;
      send_byte(VEC[v][135:128], 1'b0);
      for (int t = 0; t < 200 && tx === 1'b1; t++) @(negedge clk);
      chk("R9 led_tx during dump", 64'(led_tx), 64'd1);
      wait_bytes(base + 16);
      repeat (20) @(negedge clk);
      chk("R9 led_tx after dump", 64'(led_tx), 64'd0);
      chk("R6 byte count", 64'(rcount - base), 64'd16);
      chk_dump("R6 dump order", base);
    end
    chk("R6 stop bits", 64'(stopbad), 64'd0);

    // R5 image untouched by readback triggers
    chk_word("R5 word0 kept", 0);
    chk_word("R5 word15 kept", 15);
    chk("R5 still readback", 64'(led_prog), 64'd0);

    // R7 glitch in readback mode starts nothing
    base = rcount;
    @(negedge clk) rx = 1'b0;
    repeat (2) @(negedge clk);
    rx = 1'b1;
    repeat (400) @(negedge clk);
    chk("R7 no dump from glitch", 64'(rcount - base), 64'd0);
    chk("R7 led_tx quiet", 64'(led_tx), 64'd0);

    // R8 second trigger swept across a dump
    write_dmem(32'hC0FFEE01, 32'h0BADF00D, 32'h600DCAFE, 32'h7E57AB1E);
    for (int off = 0; off < 7; off++) begin
      base = rcount;
      send_byte(8'h3C, 1'b0);
      repeat (40 + off * 230) @(negedge clk);
      send_byte(8'hC3, 1'b0);
      if (off == 2) send_byte(8'h99, 1'b0);
      wait_bytes(base + 32);
      repeat (3000) @(negedge clk);
      chk("R8 exactly two dumps", 64'(rcount - base), 64'd32);
      chk_dump("R8 first dump", base);
      chk_dump("R8 second dump", base + 16);
    end

    // R2 another rate after reset
    do_reset();
    chk("R1 led_prog after second reset", 64'(led_prog), 64'd1);
    P = 12;
    send_byte(8'h55, 1'b0);
    repeat (2 * P) @(negedge clk);
    for (int i = 0; i < 64; i++) img[i] = 8'((i * 5 + 3) & 255);
    for (int i = 0; i < 64; i++) send_byte(img[i], 1'b0);
    repeat (4) @(negedge clk);
    chk("R2 readback at rate 12", 64'(led_prog), 64'd0);
    chk_word("R2 word0 at rate 12", 0);
    chk_word("R2 word15 at rate 12", 15);
    write_dmem(32'h89ABCDEF, 32'h01234567, 32'hFEDCBA98, 32'h76543210);
    base = rcount;
    send_byte(8'h00, 1'b0);
    wait_bytes(base + 16);
    repeat (40) @(negedge clk);
    chk("R2 count at rate 12", 64'(rcount - base), 64'd16);
    chk_dump("R2 dump at rate 12", base);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule